// File: doc/BRIEF.md
# Three-Wire Write-Only Control Register Slave

This block is a serial configuration port for a small bank of control registers. A host lowers the chip-select line and clocks in a 16-bit frame over a serial clock and data line. The frame carries a 2-bit device identifier, a direction bit, a 5-bit register address and an 8-bit value. The value reaches the addressed register only when chip select is released, and only if the frame was well formed. The register contents drive a set of parallel configuration outputs. One register bit also produces a one-cycle strobe that resets downstream timing logic.

All serial inputs, the power-down input and the master clock are brought into the system clock domain through two-flop synchronisers. An activity detector watches the synchronised master clock. It blocks register updates when no master-clock edge has been seen for a set number of system cycles. Holding the power-down input low returns every register to its default value and blocks all writes.

Top module: `ctl3w_regbank`

## Requirements
- R1: A frame is 16 bits, most significant first: identifier bits 15:14, direction bit 13, address bits 12:8, data bits 7:0. It is accepted only if the identifier is binary 01.
- R2: Serial data is captured on the rising edge of the serial clock. The host changes data while the serial clock is low.
- R3: A frame takes effect only when chip select rises. It is discarded if that rise comes after any bit count other than exactly 16.
- R4: A frame whose identifier is not 01, or whose direction bit is 0, changes no register.
- R5: Only addresses 0 to 4 hold registers. A frame addressed to 5 through 31 changes no output.
- R6: The register fields are laid out as follows.
  - Address 0: bit 7 is clk_sel, bits 4:2 are data_fmt, bit 1 is pwr_on and bit 0 is soft_rst_n.
  - Address 1: bits 5:4 are rate_sel, bits 3:2 are deemph and bit 1 is smute.
  - Address 2: bit 5 is inv_l and bit 4 is inv_r.
  - Address 3 is att_l and address 4 is att_r.
  - Unlisted bits are stored as 0.
- R7: After rst_n, every field is 0 except pwr_on and soft_rst_n, which are 1.
- R8: While pdn_n is low, every field holds its R7 default and frames are ignored.
- R9: When the master clock has shown no edge for MCLK_TIMEOUT system cycles, frames are ignored. Writes resume once edges return.
- R10: A write that clears soft_rst_n while it is 1 gives a single-cycle pulse on timing_rst and changes no other register. Writes are still accepted while pwr_on or soft_rst_n is 0.
- R11: A valid frame updates the outputs on the fourth system clock edge after chip select rises, and not earlier. Power-down defaults appear on the third edge after pdn_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Asynchronous power-down, active low |
| mclk | input | 1 | Master clock, monitored for activity |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| clk_sel | output | 1 | Clock-select field |
| data_fmt | output | 3 | Data-format field |
| pwr_on | output | 1 | Power field |
| soft_rst_n | output | 1 | Soft-reset field, 0 = timing held in reset |
| rate_sel | output | 2 | Sample-rate field |
| deemph | output | 2 | De-emphasis field |
| smute | output | 1 | Soft-mute field |
| inv_l | output | 1 | Left-channel invert |
| inv_r | output | 1 | Right-channel invert |
| att_l | output | 8 | Left attenuation |
| att_r | output | 8 | Right attenuation |
| timing_rst | output | 1 | One-cycle timing-reset strobe |

## Verification
Changes caused by a frame are due at the ports on the fourth system clock edge after chip select rises. That count is two synchroniser stages, one edge-detect register and the register write. Power-down defaults are due on the third edge after pdn_n falls, and the timing_rst strobe lasts exactly the one cycle of its write. The bench model applies each update exactly that many rising edges after it drives the input, and compares every output at every falling edge. A result that is early, late or too long is therefore reported, as well as a wrong value.

// File: rtl/ctl3w_pkg.sv
// Package: shared constants and per-register helpers for the control slave.
// Assumes register indices 0..NUM_REGS-1 map straight to frame addresses.
package ctl3w_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_REGS   = 5;
    localparam logic [1:0] DEV_ID = 2'b01;

    // Bits that physically exist in each register; others store 0.
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            0:       return 8'h9F;
            1:       return 8'h3E;
            2:       return 8'h30;
            default: return 8'hFF;
        endcase
    endfunction

    // Value loaded by reset and power-down.
    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        return (idx == 0) ? 8'h03 : 8'h00;
    endfunction
endpackage

// File: rtl/ctl3w_sync.sv
// Module: two-flop synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives each bit its idle level.
module ctl3w_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    // Two metastability stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/ctl3w_mclk_mon.sv
// Module: master-clock activity detector.
// Assumes the monitored clock is already synchronised and is slower than
// half the system clock. Absent until the first edge after reset.
module ctl3w_mclk_mon #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_s,
    output logic mclk_ok
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic             prev_q;
    logic [CNT_W-1:0] idle_q;

    // Count cycles since the last edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            idle_q <= LIMIT;
        end else begin
            prev_q <= mclk_s;
            if (prev_q != mclk_s)
                idle_q <= '0;
            else if (idle_q != LIMIT)
                idle_q <= idle_q + 1'b1;
        end
    end

    assign mclk_ok = (idle_q != LIMIT);
endmodule

// File: rtl/ctl3w_frame_rx.sv
// Module: serial frame receiver. Shifts on serial-clock rises while chip
// select is low and issues a one-cycle write request on chip-select rise
// when exactly FRAME_BITS bits arrived with a good identifier and write bit.
// Assumes synchronised inputs.
module ctl3w_frame_rx
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              wr_v,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_BITS + 1);

    logic                  csn_q, sclk_q;
    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  cs_rise, good;

    assign cs_rise = csn_s && !csn_q;
    assign good    = (cnt_q == FULL) && (sr_q[15:14] == DEV_ID) && sr_q[13];

    // Edge history for chip select and serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csn_q  <= csn_s;
            sclk_q <= sclk_s;
        end
    end

    // Shift register and saturating bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (csn_s) begin
            cnt_q <= '0;
        end else if (sclk_s && !sclk_q) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], sdat_s};
            if (cnt_q != OVER)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // One-cycle write request on chip-select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_v    <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_v <= cs_rise && good;
            if (cs_rise) begin
                wr_addr <= sr_q[DATA_W +: ADDR_W];
                wr_data <= sr_q[DATA_W-1:0];
            end
        end
    end

    AST_REQ_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_v |-> csn_s); // R3
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_v |=> !wr_v); // R3
endmodule

// File: rtl/ctl3w_regfile.sv
// Module: configuration register bank. Applies masked writes when the master
// clock is present and power-down is released. Pulses timing_rst when the
// soft-reset bit is cleared. Assumes wr_v lasts one cycle.
module ctl3w_regfile
    import ctl3w_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pdn_s,
    input  logic                       mclk_ok,
    input  logic                       wr_v,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       timing_rst
);
    logic wr_en;
    assign wr_en = wr_v && mclk_ok;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        // One register: defaults on reset or power-down, else masked write.
        always_ff @(posedge clk) begin
            if (!rst_n || !pdn_s)
                r_q <= reset_value(i);
            else if (wr_en && wr_addr == ADDR_W'(i))
                r_q <= wr_data & field_mask(i);
        end
        assign regs_o[i*DATA_W +: DATA_W] = r_q;
    end

    // Strobe when a write takes the soft-reset bit from 1 to 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_s)
            timing_rst <= 1'b0;
        else
            timing_rst <= wr_en && (wr_addr == '0) && regs_o[0] && !wr_data[0];
    end

    AST_PDN_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_s |=> (regs_o[DATA_W-1:0] == 8'h03) && (regs_o[NUM_REGS*DATA_W-1:DATA_W] == '0)); // R8
    AST_NO_WRITE_NO_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_v && !mclk_ok && pdn_s) |=> $stable(regs_o)); // R9
    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_v && int'(wr_addr) >= NUM_REGS && pdn_s) |=> $stable(regs_o)); // R5
    AST_TRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        timing_rst |=> !timing_rst); // R10
    AST_TRST_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        timing_rst |-> !regs_o[0]); // R10
endmodule

// File: rtl/ctl3w_regbank.sv
// Module: top of the three-wire write-only control slave. Synchronises the
// asynchronous inputs, receives frames, monitors the master clock and holds
// the register bank. Assumes the serial clock is at most one eighth of clk.
module ctl3w_regbank
    import ctl3w_pkg::*;
#(
    parameter int MCLK_TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n,
    input  logic       mclk,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdata,
    output logic       clk_sel,
    output logic [2:0] data_fmt,
    output logic       pwr_on,
    output logic       soft_rst_n,
    output logic [1:0] rate_sel,
    output logic [1:0] deemph,
    output logic       smute,
    output logic       inv_l,
    output logic       inv_r,
    output logic [7:0] att_l,
    output logic [7:0] att_r,
    output logic       timing_rst
);
    logic [4:0] sync_q;
    logic       pdn_s, mclk_s, csn_s, sclk_s, sdat_s, mclk_ok;
    logic              wr_v;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [NUM_REGS*DATA_W-1:0] regs;

    ctl3w_sync #(.W(5), .RST_VAL(5'b00100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({pdn_n, mclk, cs_n, sclk, sdata}), .q_o(sync_q)
    );
    assign {pdn_s, mclk_s, csn_s, sclk_s, sdat_s} = sync_q;

    ctl3w_mclk_mon #(.TIMEOUT(MCLK_TIMEOUT)) u_mon (
        .clk(clk), .rst_n(rst_n), .mclk_s(mclk_s), .mclk_ok(mclk_ok)
    );

    ctl3w_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sclk_s(sclk_s),
        .sdat_s(sdat_s), .wr_v(wr_v), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    ctl3w_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .pdn_s(pdn_s), .mclk_ok(mclk_ok),
        .wr_v(wr_v), .wr_addr(wr_addr), .wr_data(wr_data),
        .regs_o(regs), .timing_rst(timing_rst)
    );

    // Field decode of the register bank.
    assign clk_sel    = regs[7];
    assign data_fmt   = regs[4:2];
    assign pwr_on     = regs[1];
    assign soft_rst_n = regs[0];
    assign rate_sel   = regs[13:12];
    assign deemph     = regs[11:10];
    assign smute      = regs[9];
    assign inv_l      = regs[21];
    assign inv_r      = regs[20];
    assign att_l      = regs[31:24];
    assign att_r      = regs[39:32];
endmodule

// File: tb/ctl3w_regbank_tb.sv
// Bench: behavioural register model, compared with every output at every
// falling clock edge, plus named checks after each scenario.
module ctl3w_regbank_tb;
    logic clk = 0, rst_n = 0, pdn_n = 1, mclk = 0, cs_n = 1, sclk = 0, sdata = 0;
    logic       clk_sel, pwr_on, soft_rst_n, smute, inv_l, inv_r, timing_rst;
    logic [2:0] data_fmt;
    logic [1:0] rate_sel, deemph;
    logic [7:0] att_l, att_r;

    int checks = 0, failures = 0, trst_seen = 0;
    bit cmp_en = 0, done = 0, mclk_run = 1, mclk_good = 1, pdn_lvl = 1;
    logic [7:0] m [5];
    logic exp_trst = 0;

    ctl3w_regbank u_dut (.*);

    always #5 clk = ~clk;
    always begin #20; if (mclk_run) mclk = ~mclk; end

    function automatic logic [7:0] msk(input int a);
        case (a) 0: return 8'h9F; 1: return 8'h3E; 2: return 8'h30; default: return 8'hFF; endcase
    endfunction

    function automatic logic [29:0] obs();
        return {clk_sel, data_fmt, pwr_on, soft_rst_n, rate_sel, deemph, smute,
                inv_l, inv_r, att_l, att_r, timing_rst};
    endfunction

    function automatic logic [29:0] expv();
        return {m[0][7], m[0][4:2], m[0][1], m[0][0], m[1][5:4], m[1][3:2], m[1][1],
                m[2][5], m[2][4], m[3], m[4], exp_trst};
    endfunction

    task automatic set_defaults();
        m[0] = 8'h03; m[1] = 0; m[2] = 0; m[3] = 0; m[4] = 0;
    endtask

    task automatic chk(input string tag);
        checks++;
        if (obs() !== expv()) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, obs(), expv());
        end
    endtask

    // R11: every-cycle comparison against the model
    always @(negedge clk) if (cmp_en) begin
        if (timing_rst) trst_seen++;
        chk("R11 per-cycle");
    end

    task automatic send(input logic [31:0] bits, input int n);
        logic ok; int a; logic [7:0] d;
        a = int'(bits[12:8]); d = bits[7:0];
        ok = (n == 16) && bits[15:14] == 2'b01 && bits[13] && pdn_lvl && mclk_good && a <= 4;
        @(negedge clk); cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 0; sdata = bits[i];
            repeat (4) @(negedge clk);
            sclk = 1;
            repeat (4) @(negedge clk);
        end
        sclk = 0;
        repeat (4) @(negedge clk);
        cs_n = 1;
        repeat (4) @(posedge clk); #1;
        if (ok) begin
            if (a == 0 && m[0][0] && !d[0]) exp_trst = 1;
            m[a] = d & msk(a);
        end
        @(posedge clk); #1 exp_trst = 0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] fr(input logic [1:0] id, input logic rw,
                                       input logic [4:0] a, input logic [7:0] d);
        return {16'h0, id, rw, a, d};
    endfunction

    initial begin
        int t0;
        set_defaults();
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (20) @(negedge clk);
        cmp_en = 1;
        chk("R7 reset defaults");

        send(fr(2'b01, 1, 5'd3, 8'h5A), 16); chk("R1 R2 att_l write");
        send(fr(2'b01, 1, 5'd4, 8'hC3), 16); chk("R6 att_r write");
        send(fr(2'b01, 1, 5'd1, 8'hFF), 16); chk("R6 reg1 masked");
        send(fr(2'b01, 1, 5'd2, 8'hFF), 16); chk("R6 reg2 masked");

        t0 = trst_seen;
        send(fr(2'b01, 1, 5'd0, 8'h9C), 16); chk("R10 clear soft reset");
        checks++;
        if (trst_seen - t0 != 1) begin
            failures++; $display("FAIL R10 pulse count actual=%0d expected=1", trst_seen - t0);
        end
        send(fr(2'b01, 1, 5'd3, 8'h11), 16); chk("R10 write with pwr/soft reset 0");
        t0 = trst_seen;
        send(fr(2'b01, 1, 5'd0, 8'h80), 16); chk("R10 no pulse when already 0");
        checks++;
        if (trst_seen != t0) begin
            failures++; $display("FAIL R10 spurious pulse actual=%0d expected=0", trst_seen - t0);
        end
        send(fr(2'b01, 1, 5'd0, 8'h03), 16);

        send(fr(2'b00, 1, 5'd3, 8'hEE), 16); chk("R4 bad identifier");
        send(fr(2'b11, 1, 5'd3, 8'hEE), 16); chk("R1 identifier 11");
        send(fr(2'b01, 0, 5'd3, 8'hEE), 16); chk("R4 direction bit 0");
        send(fr(2'b01, 1, 5'd3, 8'hEE) >> 1, 15); chk("R3 15 bits");
        send({fr(2'b01, 1, 5'd3, 8'hEE), 1'b1}, 17); chk("R3 17 bits");
        send(fr(2'b01, 1, 5'd5, 8'hEE), 16); chk("R5 address 5");
        send(fr(2'b01, 1, 5'd31, 8'hEE), 16); chk("R5 address 31");

        mclk_run = 0; mclk_good = 0;
        repeat (40) @(negedge clk);
        send(fr(2'b01, 1, 5'd4, 8'h77), 16); chk("R9 no master clock");
        mclk_run = 1;
        repeat (20) @(negedge clk);
        mclk_good = 1;
        send(fr(2'b01, 1, 5'd4, 8'h78), 16); chk("R9 master clock back");

        @(negedge clk); pdn_n = 0;
        repeat (3) @(posedge clk); #1 set_defaults(); pdn_lvl = 0;
        repeat (3) @(negedge clk); chk("R8 power-down defaults");
        send(fr(2'b01, 1, 5'd3, 8'h42), 16); chk("R8 write during power-down");
        @(negedge clk); pdn_n = 1;
        repeat (5) @(negedge clk); pdn_lvl = 1;
        send(fr(2'b01, 1, 5'd3, 8'h42), 16); chk("R8 write after power-down");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule